// File: doc/BRIEF.md
# Converter Output Gain/Offset Corrector with Overrange Detection

This block forms the last arithmetic step of a sigma-delta converter's digital back end. Each decimated sample word is scaled by a programmable unsigned gain and then shifted by a programmable signed offset. Both steps clamp at the output code limits instead of wrapping. The corrected word leaves a two-stage pipeline together with a data-valid status bit.

Overrange is watched on two paths that do not depend on the correction settings. The first compares the magnitude of the first decimation stage output with a programmable threshold, ahead of any gain or offset. The second counts runs of rail-level modulator codes and trips as soon as such a run grows longer than a set length. Either path raises a level-type overrange flag. While that flag is high, samples leave the pipeline with their data-valid bit cleared. Gain, offset and threshold are set through a small write-only register port.

Top module: `adc_gain_offset_ovr`

## Requirements
- R1: After reset the gain is 1.25 (code 0xA000), the offset is 0, the threshold is 0xCCCC, and out_vld, out_dvalid and ovr_flag are all low.
- R2: A write with cfg_wr_en high stores cfg_wr_data into the gain at address 0, the offset at address 1 or the threshold at address 2; a write to address 3 changes nothing.
- R3: The gain stage yields p = floor(x * G / 32768) for signed input x and unsigned 16-bit gain code G, so 0x8000 is unity.
- R4: The offset is applied after the gain stage: out = p + floor(O / 128), where O is the offset code read as 16-bit two's complement (0x7FFF adds 255, 0x8000 adds -256).
- R5: The gain result and the offset sum each clamp to 32767 or -32768 instead of wrapping.
- R6: A sample taken with smp_vld high appears on out_data with out_vld high exactly two clock edges later, and out_vld is low one edge after the sample is taken.
- R7: On each stg1_vld the first-stage check is recomputed as 2*|s| > T, with s the signed 16-bit first-stage word and T the unsigned 16-bit threshold code. The check holds its value between strobes.
- R8: The modulator codes +127 and -128 (8-bit signed) count as full scale. The modulator trip is set from the fifth consecutive full-scale code on mod_vld, and any other code with mod_vld clears it.
- R9: ovr_flag is the OR of the first-stage check and the modulator trip, and drops as soon as both clear.
- R10: out_dvalid is the inverse of ovr_flag in the cycle between the sample being taken and its result appearing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 2 | Register select: 0 gain, 1 offset, 2 threshold |
| cfg_wr_data | input | 16 | Register write value |
| smp_vld | input | 1 | Decimated sample strobe |
| smp_data | input | 16 | Decimated sample, signed |
| stg1_vld | input | 1 | First decimation stage output strobe |
| stg1_data | input | 16 | First decimation stage output, signed |
| mod_vld | input | 1 | Modulator code strobe |
| mod_data | input | 8 | Modulator code, signed |
| out_vld | output | 1 | Corrected sample strobe |
| out_data | output | 16 | Corrected sample, signed |
| out_dvalid | output | 1 | Data-valid bit for the corrected sample |
| ovr_flag | output | 1 | Overrange status, level |

## Verification
A wrong gain or offset register, or a bad shift or clamp, shows up two edges after the affected sample as an out_data word that differs from floor arithmetic. The sweeps over many input words, gains and offsets reveal this on the first sample that hits the faulty range. A fault in the run counter shifts the ovr_flag edge away from the fifth rail code, or leaves the flag set after a non-rail code, and this is visible one edge after the strobe. A wrong first-stage compare shows as a flag error on the word one code either side of the threshold.

// File: rtl/ago_pkg.sv
package ago_pkg;
   typedef enum logic [1:0] {
      CFG_GAIN   = 2'd0,
      CFG_OFFSET = 2'd1,
      CFG_THRESH = 2'd2,
      CFG_SPARE  = 2'd3
   } cfg_addr_e;
endpackage

// File: rtl/ago_regs.sv
module ago_regs
   import ago_pkg::*;
#(
   parameter int REG_W  = 16,
   parameter int GAIN_W = 16,
   parameter int OFS_W  = 16,
   parameter int THR_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [GAIN_W-1:0] gain,
   output logic [OFS_W-1:0]  ofs,
   output logic [THR_W-1:0]  thr
);
   // gain 1.25 = binary 1.01 with unity at the top bit
   localparam logic [GAIN_W-1:0] GAIN_RST = {3'b101, {(GAIN_W-3){1'b0}}};
   // 80 % of the unsigned threshold span
   localparam logic [THR_W-1:0]  THR_RST  =
      THR_W'((((64'd1 << THR_W) - 64'd1) * 64'd4) / 64'd5);

   cfg_addr_e sel;
   assign sel = cfg_addr_e'(wr_addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gain <= GAIN_RST;
         ofs  <= '0;
         thr  <= THR_RST;
      end else if (wr_en) begin
         case (sel)
            CFG_GAIN:   gain <= wr_data[GAIN_W-1:0];
            CFG_OFFSET: ofs  <= wr_data[OFS_W-1:0];
            CFG_THRESH: thr  <= wr_data[THR_W-1:0];
            default:    ;
         endcase
      end
   end

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable({gain, ofs, thr}));  // R2
   AST_SPARE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd3) |=> $stable({gain, ofs, thr}));  // R2
endmodule

// File: rtl/ago_datapath.sv
module ago_datapath #(
   parameter int DW        = 16,
   parameter int GW        = 16,
   parameter int OW        = 16,
   parameter int OFS_SHIFT = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_vld,
   input  logic signed [DW-1:0] in_data,
   input  logic [GW-1:0]        gain,
   input  logic signed [OW-1:0] ofs,
   input  logic                 ovr,
   output logic                 out_vld,
   output logic signed [DW-1:0] out_data,
   output logic                 out_dvalid
);
   localparam int PW = DW + GW + 1;
   localparam int SW = ((DW > OW) ? DW : OW) + 2;
   localparam logic signed [DW-1:0] D_MAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic signed [DW-1:0] D_MIN = {1'b1, {(DW-1){1'b0}}};
   localparam logic signed [PW-1:0] P_MAX = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [PW-1:0] P_MIN = ~P_MAX;
   localparam logic signed [SW-1:0] S_MAX = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [SW-1:0] S_MIN = ~S_MAX;

   // stage 1: multiply, rescale, clamp
   logic signed [PW-1:0] prod, prod_sh;
   logic signed [DW-1:0] gain_sat, p_q;
   logic                 vld1;

   assign prod    = PW'(in_data) * PW'($signed({1'b0, gain}));
   assign prod_sh = prod >>> (GW - 1);

   always_comb begin
      if (prod_sh > P_MAX)      gain_sat = D_MAX;
      else if (prod_sh < P_MIN) gain_sat = D_MIN;
      else                      gain_sat = DW'(prod_sh);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld1 <= 1'b0;
         p_q  <= '0;
      end else begin
         vld1 <= in_vld;
         if (in_vld) p_q <= gain_sat;
      end
   end

   // stage 2: scaled offset, clamp
   logic signed [OW-1:0] ofs_sc;
   logic signed [SW-1:0] sum;
   logic signed [DW-1:0] sum_sat;

   assign ofs_sc = ofs >>> OFS_SHIFT;
   assign sum    = SW'(p_q) + SW'(ofs_sc);

   always_comb begin
      if (sum > S_MAX)      sum_sat = D_MAX;
      else if (sum < S_MIN) sum_sat = D_MIN;
      else                  sum_sat = DW'(sum);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld    <= 1'b0;
         out_data   <= '0;
         out_dvalid <= 1'b0;
      end else begin
         out_vld <= vld1;
         if (vld1) begin
            out_data   <= sum_sat;
            out_dvalid <= ~ovr;
         end
      end
   end

   AST_PIPE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      vld1 |=> out_vld);  // R6
   AST_PIPE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !vld1 |=> !out_vld);  // R6
   AST_CLAMP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (vld1 && p_q == D_MAX && !ofs[OW-1]) |=> (out_data == D_MAX));  // R5
   AST_CLAMP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
      (vld1 && p_q == D_MIN && ofs[OW-1]) |=> (out_data == D_MIN));  // R5
   AST_DVALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (vld1 && ovr) |=> (out_vld && !out_dvalid));  // R10
endmodule

// File: rtl/ago_ovr_mon.sv
module ago_ovr_mon #(
   parameter int DW          = 16,
   parameter int TW          = 16,
   parameter int MW          = 8,
   parameter int RUN_LEN     = 4,
   parameter bit MOD_TRIP_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 stg_vld,
   input  logic signed [DW-1:0] stg_data,
   input  logic [TW-1:0]        thr,
   input  logic                 mod_vld,
   input  logic signed [MW-1:0] mod_data,
   output logic                 ovr
);
   localparam int UP = TW - DW + 1;

   // first-stage magnitude against threshold
   logic [DW-1:0] mag;
   logic [TW:0]   mag_sc;
   logic          stg_ovr;

   assign mag    = stg_data[DW-1] ? DW'(-stg_data) : DW'(stg_data);
   assign mag_sc = (TW+1)'(mag) << UP;

   always_ff @(posedge clk) begin
      if (!rst_n)       stg_ovr <= 1'b0;
      else if (stg_vld) stg_ovr <= (mag_sc > {1'b0, thr});
   end

   AST_STG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !stg_vld |=> $stable(stg_ovr));  // R7

   // modulator run detector
   logic mod_ovr;

   if (MOD_TRIP_EN) begin : g_mod_trip
      localparam int CNT_W = $clog2(RUN_LEN + 2);
      localparam logic [CNT_W-1:0] LIM = CNT_W'(RUN_LEN);
      logic [CNT_W-1:0] run_q;
      logic             rail;

      assign rail = (mod_data == {1'b0, {(MW-1){1'b1}}}) ||
                    (mod_data == {1'b1, {(MW-1){1'b0}}});

      always_ff @(posedge clk) begin
         if (!rst_n) run_q <= '0;
         else if (mod_vld) begin
            if (!rail)            run_q <= '0;
            else if (run_q <= LIM) run_q <= run_q + 1'b1;
         end
      end

      assign mod_ovr = (run_q > LIM);

      AST_RUN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
         (mod_vld && !rail) |=> !mod_ovr);  // R8
      AST_RUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(mod_ovr) |-> $past(mod_vld && rail));  // R8
   end else begin : g_no_mod_trip
      assign mod_ovr = 1'b0;
   end

   assign ovr = stg_ovr | mod_ovr;

   AST_FLAG_SOURCES: assert property (@(posedge clk) disable iff (!rst_n)
      (!stg_ovr && !mod_ovr) |-> !ovr);  // R9
endmodule

// File: rtl/adc_gain_offset_ovr.sv
module adc_gain_offset_ovr #(
   parameter int DATA_W      = 16,
   parameter int REG_W       = 16,
   parameter int GAIN_W      = 16,
   parameter int OFS_W       = 16,
   parameter int THR_W       = 16,
   parameter int OFS_SHIFT   = 7,
   parameter int MOD_W       = 8,
   parameter int RUN_LEN     = 4,
   parameter bit MOD_TRIP_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_wr_en,
   input  logic [1:0]               cfg_wr_addr,
   input  logic [REG_W-1:0]         cfg_wr_data,
   input  logic                     smp_vld,
   input  logic signed [DATA_W-1:0] smp_data,
   input  logic                     stg1_vld,
   input  logic signed [DATA_W-1:0] stg1_data,
   input  logic                     mod_vld,
   input  logic signed [MOD_W-1:0]  mod_data,
   output logic                     out_vld,
   output logic signed [DATA_W-1:0] out_data,
   output logic                     out_dvalid,
   output logic                     ovr_flag
);
   if (GAIN_W > REG_W || OFS_W > REG_W || THR_W > REG_W) begin : g_bad_reg_w
      $error("register field wider than write port");
   end
   if (GAIN_W < 3) begin : g_bad_gain_w
      $error("gain field too narrow for its reset value");
   end
   if (THR_W < DATA_W - 1) begin : g_bad_thr_w
      $error("threshold field narrower than sample magnitude");
   end
   if (OFS_SHIFT >= OFS_W) begin : g_bad_shift
      $error("offset shift consumes the whole offset field");
   end
   if (RUN_LEN < 1 || MOD_W < 2) begin : g_bad_run
      $error("modulator run settings out of range");
   end

   logic [GAIN_W-1:0] gain;
   logic [OFS_W-1:0]  ofs;
   logic [THR_W-1:0]  thr;

   ago_regs #(
      .REG_W (REG_W), .GAIN_W(GAIN_W), .OFS_W(OFS_W), .THR_W(THR_W)
   ) i_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_wr_en),
      .wr_addr(cfg_wr_addr),
      .wr_data(cfg_wr_data),
      .gain   (gain),
      .ofs    (ofs),
      .thr    (thr)
   );

   ago_ovr_mon #(
      .DW(DATA_W), .TW(THR_W), .MW(MOD_W),
      .RUN_LEN(RUN_LEN), .MOD_TRIP_EN(MOD_TRIP_EN)
   ) i_ovr_mon (
      .clk     (clk),
      .rst_n   (rst_n),
      .stg_vld (stg1_vld),
      .stg_data(stg1_data),
      .thr     (thr),
      .mod_vld (mod_vld),
      .mod_data(mod_data),
      .ovr     (ovr_flag)
   );

   ago_datapath #(
      .DW(DATA_W), .GW(GAIN_W), .OW(OFS_W), .OFS_SHIFT(OFS_SHIFT)
   ) i_datapath (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_vld    (smp_vld),
      .in_data   (smp_data),
      .gain      (gain),
      .ofs       ($signed(ofs)),
      .ovr       (ovr_flag),
      .out_vld   (out_vld),
      .out_data  (out_data),
      .out_dvalid(out_dvalid)
   );
endmodule

// File: tb/test_adc_gain_offset_ovr.sv
module test_adc_gain_offset_ovr;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr_en = 1'b0;
   logic [1:0] cfg_wr_addr = '0;
   logic [15:0] cfg_wr_data = '0;
   logic smp_vld = 1'b0;
   logic signed [15:0] smp_data = '0;
   logic stg1_vld = 1'b0;
   logic signed [15:0] stg1_data = '0;
   logic mod_vld = 1'b0;
   logic signed [7:0] mod_data = '0;
   logic out_vld, out_dvalid, ovr_flag;
   logic signed [15:0] out_data;

   int n_chk = 0;
   int n_err = 0;

   always #10ns clk = ~clk;

   adc_gain_offset_ovr i_adc_gain_offset_ovr (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr), .cfg_wr_data(cfg_wr_data),
      .smp_vld(smp_vld), .smp_data(smp_data),
      .stg1_vld(stg1_vld), .stg1_data(stg1_data),
      .mod_vld(mod_vld), .mod_data(mod_data),
      .out_vld(out_vld), .out_data(out_data),
      .out_dvalid(out_dvalid), .ovr_flag(ovr_flag)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint clamp(input longint v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   function automatic longint model(input longint x, input longint g, input logic [15:0] o);
      longint p;
      p = clamp((x * g) >>> 15);
      return clamp(p + (longint'($signed(o)) >>> 7));
   endfunction

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic send(input longint x, output longint y, output logic dv);
      @(negedge clk);
      smp_vld = 1'b1; smp_data = 16'(x);
      @(negedge clk);
      smp_vld = 1'b0;
      chk("R6 out_vld low after one edge", longint'(out_vld), 0);
      @(negedge clk);
      chk("R6 out_vld high after two edges", longint'(out_vld), 1);
      y = longint'(out_data);
      dv = out_dvalid;
   endtask

   task automatic stg(input longint s);
      @(negedge clk);
      stg1_vld = 1'b1; stg1_data = 16'(s);
      @(negedge clk);
      stg1_vld = 1'b0;
   endtask

   task automatic modc(input longint m);
      @(negedge clk);
      mod_vld = 1'b1; mod_data = 8'(m);
      @(negedge clk);
      mod_vld = 1'b0;
   endtask

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      longint y, e;
      logic dv;
      longint gains [6] = '{32768, 40960, 16384, 65535, 1, 4660};
      logic [15:0] offs [4] = '{16'h0000, 16'h7FFF, 16'h8000, 16'h0123};

      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 out_vld after reset", longint'(out_vld), 0);
      chk("R1 out_dvalid after reset", longint'(out_dvalid), 0);
      @(negedge clk) rst_n = 1'b1;
      chk("R1 ovr_flag after reset", longint'(ovr_flag), 0);

      // R1: defaults gain 1.25, offset 0
      send(20000, y, dv);
      chk("R1 default gain", y, model(20000, 40960, 16'h0000));
      chk("R1 default dvalid", longint'(dv), 1);
      // R1: default threshold 0xCCCC: 2*26214 is not above it, 26215 is
      stg(26214);
      chk("R1 default threshold edge below", longint'(ovr_flag), 0);
      stg(26215);
      chk("R1 default threshold edge above", longint'(ovr_flag), 1);
      stg(0);

      // R3 R4 R5 sweep over gains, offsets, inputs
      foreach (gains[gi]) begin
         foreach (offs[oi]) begin
            wr(2'd0, 16'(gains[gi]));
            wr(2'd1, offs[oi]);
            for (longint x = -32768; x <= 32767; x += 2053) begin
               send(x, y, dv);
               chk("R3 R4 corrected word", y, model(x, gains[gi], offs[oi]));
            end
            send(32767, y, dv);
            chk("R5 top input", y, model(32767, gains[gi], offs[oi]));
            send(-32768, y, dv);
            chk("R5 bottom input", y, model(-32768, gains[gi], offs[oi]));
         end
      end

      // R5 explicit clamp values
      wr(2'd0, 16'hFFFF); wr(2'd1, 16'h7FFF);
      send(32767, y, dv);
      chk("R5 positive clamp", y, 32767);
      wr(2'd1, 16'h8000);
      send(-32768, y, dv);
      chk("R5 negative clamp", y, -32768);
      // R4 offset after gain: gain clamps first, then offset pulls back in range
      send(32767, y, dv);
      chk("R4 offset after clamped gain", y, 32767 - 256);

      // R2 spare address ignored, offset read back via output
      wr(2'd0, 16'h8000); wr(2'd1, 16'h0000);
      wr(2'd3, 16'h1234);
      send(1000, y, dv);
      chk("R2 spare write ignored", y, 1000);
      wr(2'd1, 16'h0280);
      send(1000, y, dv);
      chk("R2 offset write", y, 1005);
      wr(2'd1, 16'h0000);

      // R7 custom threshold and hold between strobes
      wr(2'd2, 16'd2000);
      stg(1000);
      chk("R7 at threshold not set", longint'(ovr_flag), 0);
      stg(-1001);
      chk("R7 negative above threshold", longint'(ovr_flag), 1);
      repeat (3) @(negedge clk);
      chk("R7 held without strobe", longint'(ovr_flag), 1);
      stg(-32768);
      chk("R7 most negative", longint'(ovr_flag), 1);
      // R10 dvalid cleared during overrange
      send(500, y, dv);
      chk("R10 dvalid low", longint'(dv), 0);
      stg(-1000);
      chk("R9 flag clears", longint'(ovr_flag), 0);
      send(500, y, dv);
      chk("R10 dvalid high", longint'(dv), 1);

      // R8 modulator run: four rail codes do not trip, fifth does
      for (int k = 0; k < 4; k++) begin
         modc((k % 2 == 0) ? 127 : -128);
         chk("R8 no trip before fifth rail code", longint'(ovr_flag), 0);
      end
      modc(127);
      chk("R8 trip on fifth rail code", longint'(ovr_flag), 1);
      modc(-128);
      chk("R8 trip held on longer run", longint'(ovr_flag), 1);
      send(700, y, dv);
      chk("R10 dvalid low on modulator trip", longint'(dv), 0);
      modc(126);
      chk("R9 modulator trip clears", longint'(ovr_flag), 0);
      // run broken by a non-rail code restarts
      for (int k = 0; k < 4; k++) modc(127);
      modc(0);
      modc(127);
      chk("R8 run restarts", longint'(ovr_flag), 0);
      // R9 both sources: flag stays while either one holds
      for (int k = 0; k < 5; k++) modc(-128);
      stg(5000);
      modc(3);
      chk("R9 first-stage still holds flag", longint'(ovr_flag), 1);
      stg(10);
      chk("R9 both clear", longint'(ovr_flag), 0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule